// File: doc/BRIEF.md
# Two-Cluster Replicated Register File with Forwarding

This block holds the integer register state of an execution core that is split into two clusters. Each cluster keeps its own complete copy of an 80-entry, 64-bit physical register file. Each cluster has two ALU result ports, which gives four write ports in total. A result enters the producing cluster's copy at the next clock edge. It reaches the other cluster's copy one cycle after that, through a transfer pipeline register.

Consumers read through read ports. Each read port carries a cluster index and a register tag, and returns the 64-bit value together with a valid flag. The valid flag tells whether the value is visible to that cluster yet. Two forwarding paths hide the write delay. A result is usable by its own cluster in the same cycle it is produced. It is usable by the other cluster from the transfer register one cycle later. This gives cross-cluster consumers exactly one extra cycle of latency.

A per-cluster, per-register ready vector tells the scheduler which values each cluster can consume. A single invalidate input lets the allocation stage mark a destination register as pending in both copies until its result arrives.

Top module: `ccrf_top`

## Requirements
- R1: After reset, every register in both cluster copies reads as zero with valid set, and every ready bit is 1.
- R2: A result written in cycle t is returned, with valid set, by a read in cycle t from the same cluster. Write port p belongs to cluster p / NUM_ALU.
- R3: From cycle t+1 on, the producing cluster's copy holds a result written in cycle t. A read port whose cluster index is 0 or 1 returns that cluster's copy.
- R4: A read from the other cluster in cycle t still shows the register's earlier value and valid state. In cycle t+1 it returns the new value with valid set.
- R5: From cycle t+2 on, the other cluster's copy holds the result, even after the transfer register has moved on.
- R6: An invalidate in cycle t clears valid and ready for that tag in both clusters from cycle t+1 until a result for the tag arrives, and leaves the stored data unchanged. A write that lands on the same edge as the invalidate wins over it.
- R7: When several results target one tag in the same cycle, the higher-numbered write port of a cluster wins. A cluster's own new result also wins over a result arriving from the other cluster. This order applies to both forwarding and storage.
- R8: A write whose tag is 80 or above is dropped. A read whose tag is 80 or above returns zero with valid clear.
- R9: Ready bit c*80+r equals the valid flag that a read of tag r from cluster c returns in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 2*NUM_ALU | Result valid per write port |
| wr_tag | input | 2*NUM_ALU*7 | Destination tag per write port |
| wr_data | input | 2*NUM_ALU*64 | Result value per write port |
| inv_en | input | 1 | Mark a register pending in both clusters |
| inv_tag | input | 7 | Tag to mark pending |
| rd_clu | input | NUM_RD | Cluster index per read port |
| rd_tag | input | NUM_RD*7 | Register tag per read port |
| rd_data | output | NUM_RD*64 | Read value per read port |
| rd_vld | output | NUM_RD | Value visible to the selected cluster |
| ready | output | 2*80 | Per-cluster, per-register ready bits |

## Verification
The assertions watch the following on every cycle:
- the transfer register captures each local result exactly one edge later and stays empty otherwise;
- the highest write port's result is stored locally at the next edge;
- an invalidate with no competing write clears the ready bit;
- every in-range read's valid flag matches the ready vector;
- every out-of-range read returns zero with valid clear.

Only the bench's scenarios can show the full timing asymmetry: the same result becoming readable in the producing cluster in cycle t, in the other cluster in cycle t+1, and in its stored copy from t+2 on. The same holds for the ordering between colliding ports and for the reset contents of all 160 entries.

// File: rtl/ccrf_pkg.sv
package ccrf_pkg;
  parameter int unsigned NREG = 80;
  parameter int unsigned DW   = 64;
  localparam int unsigned TW   = $clog2(NREG);
  localparam int unsigned NCLU = 2;

  typedef struct packed {
    logic          en;
    logic [TW-1:0] tag;
    logic [DW-1:0] data;
  } res_t;

  function automatic logic tag_ok(input logic [TW-1:0] t);
    return t < TW'(NREG);
  endfunction
endpackage

// File: rtl/ccrf_xfer.sv
module ccrf_xfer
  import ccrf_pkg::*;
#(
  parameter int NUM_ALU = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  res_t loc_wr [NUM_ALU],
  output res_t xf_q   [NUM_ALU]
);
  for (genvar k = 0; k < NUM_ALU; k++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        xf_q[k] <= '0;
      end else begin
        xf_q[k].en <= loc_wr[k].en;
        if (loc_wr[k].en) begin
          xf_q[k].tag  <= loc_wr[k].tag;
          xf_q[k].data <= loc_wr[k].data;
        end
      end
    end

    // R4: a local result is offered to the other cluster exactly one cycle later
    a_r4_xfer_carries: assert property (@(posedge clk) disable iff (!rst_n)
      loc_wr[k].en |=> (xf_q[k].en && xf_q[k].tag == $past(loc_wr[k].tag)
                        && xf_q[k].data == $past(loc_wr[k].data)));
    a_r4_xfer_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !loc_wr[k].en |=> !xf_q[k].en);
  end
endmodule

// File: rtl/ccrf_copy.sv
module ccrf_copy
  import ccrf_pkg::*;
#(
  parameter int NUM_ALU = 2,
  parameter int NUM_RD  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  res_t            loc_wr  [NUM_ALU],
  input  res_t            rem_wr  [NUM_ALU],
  input  logic            inv_en,
  input  logic [TW-1:0]   inv_tag,
  input  logic [TW-1:0]   rd_tag  [NUM_RD],
  output logic [DW-1:0]   rd_data [NUM_RD],
  output logic            rd_vld  [NUM_RD],
  output logic [NREG-1:0] rdy_o
);
  logic [DW-1:0]   mem_q [NREG];
  logic [DW-1:0]   mem_d [NREG];
  logic [NREG-1:0] rdy_q, rdy_d, hit_w;

  // next state: invalidate first, then arriving remote results, then own results
  always_comb begin
    mem_d = mem_q;
    rdy_d = rdy_q;
    hit_w = '0;
    if (inv_en && tag_ok(inv_tag)) rdy_d[inv_tag] = 1'b0;
    for (int k = 0; k < NUM_ALU; k++) begin
      if (rem_wr[k].en && tag_ok(rem_wr[k].tag)) begin
        mem_d[rem_wr[k].tag] = rem_wr[k].data;
        rdy_d[rem_wr[k].tag] = 1'b1;
        hit_w[rem_wr[k].tag] = 1'b1;
      end
    end
    for (int k = 0; k < NUM_ALU; k++) begin
      if (loc_wr[k].en && tag_ok(loc_wr[k].tag)) begin
        mem_d[loc_wr[k].tag] = loc_wr[k].data;
        rdy_d[loc_wr[k].tag] = 1'b1;
        hit_w[loc_wr[k].tag] = 1'b1;
      end
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mem_q[r] <= '0;
      else if (hit_w[r]) mem_q[r] <= mem_d[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= '1;
    else        rdy_q <= rdy_d;
  end

  // read ports: stored copy, overridden by remote transfer, overridden by own result
  always_comb begin
    for (int i = 0; i < NUM_RD; i++) begin
      rd_data[i] = '0;
      rd_vld[i]  = 1'b0;
      if (tag_ok(rd_tag[i])) begin
        rd_data[i] = mem_q[rd_tag[i]];
        rd_vld[i]  = rdy_q[rd_tag[i]];
        for (int k = 0; k < NUM_ALU; k++) begin
          if (rem_wr[k].en && rem_wr[k].tag == rd_tag[i]) begin
            rd_data[i] = rem_wr[k].data;
            rd_vld[i]  = 1'b1;
          end
        end
        for (int k = 0; k < NUM_ALU; k++) begin
          if (loc_wr[k].en && loc_wr[k].tag == rd_tag[i]) begin
            rd_data[i] = loc_wr[k].data;
            rd_vld[i]  = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    rdy_o = rdy_q;
    for (int k = 0; k < NUM_ALU; k++) begin
      if (rem_wr[k].en && tag_ok(rem_wr[k].tag)) rdy_o[rem_wr[k].tag] = 1'b1;
      if (loc_wr[k].en && tag_ok(loc_wr[k].tag)) rdy_o[loc_wr[k].tag] = 1'b1;
    end
  end

  // R3: the highest own port always lands in the stored copy at the next edge
  a_r3_local_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr[NUM_ALU-1].en && tag_ok(loc_wr[NUM_ALU-1].tag))
    |=> (mem_q[$past(loc_wr[NUM_ALU-1].tag)] == $past(loc_wr[NUM_ALU-1].data)
         && rdy_q[$past(loc_wr[NUM_ALU-1].tag)]));

  // R6: an uncontested invalidate clears the ready bit
  a_r6_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && tag_ok(inv_tag) && !hit_w[inv_tag]) |=> !rdy_q[$past(inv_tag)]);
endmodule

// File: rtl/ccrf_top.sv
module ccrf_top
  import ccrf_pkg::*;
#(
  parameter int NUM_ALU = 2,
  parameter int NUM_RD  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCLU*NUM_ALU-1:0]    wr_en,
  input  logic [NCLU*NUM_ALU*TW-1:0] wr_tag,
  input  logic [NCLU*NUM_ALU*DW-1:0] wr_data,
  input  logic                       inv_en,
  input  logic [TW-1:0]              inv_tag,
  input  logic [NUM_RD-1:0]          rd_clu,
  input  logic [NUM_RD*TW-1:0]       rd_tag,
  output logic [NUM_RD*DW-1:0]       rd_data,
  output logic [NUM_RD-1:0]          rd_vld,
  output logic [NCLU*NREG-1:0]       ready
);
  logic [1:0]      rs_q;
  logic            rst_ni;
  res_t            loc_wr  [NCLU][NUM_ALU];
  res_t            xf      [NCLU][NUM_ALU];
  logic [TW-1:0]   rtag    [NUM_RD];
  logic [DW-1:0]   cp_data [NCLU][NUM_RD];
  logic            cp_vld  [NCLU][NUM_RD];
  logic [NREG-1:0] cp_rdy  [NCLU];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  for (genvar i = 0; i < NUM_RD; i++) begin : g_rtag
    assign rtag[i] = rd_tag[i*TW +: TW];
  end

  for (genvar c = 0; c < NCLU; c++) begin : g_clu
    for (genvar k = 0; k < NUM_ALU; k++) begin : g_port
      localparam int P = c*NUM_ALU + k;
      assign loc_wr[c][k] = '{en: wr_en[P], tag: wr_tag[P*TW +: TW], data: wr_data[P*DW +: DW]};
    end

    ccrf_xfer #(.NUM_ALU(NUM_ALU)) u_xfer (
      .clk(clk), .rst_n(rst_ni), .loc_wr(loc_wr[c]), .xf_q(xf[c]));

    ccrf_copy #(.NUM_ALU(NUM_ALU), .NUM_RD(NUM_RD)) u_copy (
      .clk(clk), .rst_n(rst_ni), .loc_wr(loc_wr[c]), .rem_wr(xf[NCLU-1-c]),
      .inv_en(inv_en), .inv_tag(inv_tag), .rd_tag(rtag),
      .rd_data(cp_data[c]), .rd_vld(cp_vld[c]), .rdy_o(cp_rdy[c]));

    assign ready[c*NREG +: NREG] = cp_rdy[c];
  end

  for (genvar i = 0; i < NUM_RD; i++) begin : g_rd
    assign rd_data[i*DW +: DW] = rd_clu[i] ? cp_data[1][i] : cp_data[0][i];
    assign rd_vld[i]           = rd_clu[i] ? cp_vld[1][i]  : cp_vld[0][i];

    // R9: read valid agrees with the ready vector of the selected cluster
    a_r9_ready_matches: assert property (@(posedge clk) disable iff (!rst_ni)
      tag_ok(rtag[i]) |-> (rd_vld[i] == ready[32'(rd_clu[i])*NREG + 32'(rtag[i])]));
    // R8: out-of-range reads return nothing
    a_r8_oob_read: assert property (@(posedge clk) disable iff (!rst_ni)
      !tag_ok(rtag[i]) |-> (!rd_vld[i] && rd_data[i*DW +: DW] == '0));
  end
endmodule

// File: tb/sim_ccrf_top.sv
module sim_ccrf_top;
  import ccrf_pkg::*;
  localparam int NA = 2, NRD = 4, NP = 2*NA;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [NP-1:0] wr_en;
  logic [NP*TW-1:0] wr_tag;
  logic [NP*DW-1:0] wr_data;
  logic inv_en;
  logic [TW-1:0] inv_tag;
  logic [NRD-1:0] rd_clu;
  logic [NRD*TW-1:0] rd_tag;
  logic [NRD*DW-1:0] rd_data;
  logic [NRD-1:0] rd_vld;
  logic [2*NREG-1:0] ready;

  ccrf_top #(.NUM_ALU(NA), .NUM_RD(NRD)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tag(wr_tag), .wr_data(wr_data),
    .inv_en(inv_en), .inv_tag(inv_tag), .rd_clu(rd_clu), .rd_tag(rd_tag),
    .rd_data(rd_data), .rd_vld(rd_vld), .ready(ready));

  logic          b_en  [NP];
  logic [TW-1:0] b_tag [NP];
  logic [DW-1:0] b_dat [NP];
  logic          b_clu [NRD];
  logic [TW-1:0] b_rt  [NRD];

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      wr_en[p] = b_en[p];
      wr_tag[p*TW +: TW] = b_tag[p];
      wr_data[p*DW +: DW] = b_dat[p];
    end
    for (int i = 0; i < NRD; i++) begin
      rd_clu[i] = b_clu[i];
      rd_tag[i*TW +: TW] = b_rt[i];
    end
  end

  logic [DW-1:0] m_mem [2][NREG];
  logic          m_rdy [2][NREG];
  logic          m_rem [2][NREG];
  logic          p_en  [NP];
  logic [TW-1:0] p_tag [NP];
  logic [DW-1:0] p_dat [NP];

  int n_chk = 0, n_bad = 0;
  bit sweep_r1 = 1'b0;

  task automatic chk(string req, logic act_v, logic [DW-1:0] act_d, logic exp_v, logic [DW-1:0] exp_d);
    n_chk++;
    if (act_v !== exp_v || act_d !== exp_d) begin
      n_bad++;
      $display("FAIL %s: got vld=%0b data=%h, expected vld=%0b data=%h", req, act_v, act_d, exp_v, exp_d);
    end
  endtask

  task automatic predict(int c, int r, output logic [DW-1:0] d, output logic v, output string req);
    int nh = 0;
    if (r >= NREG) begin
      d = '0; v = 1'b0; req = "R8"; return;
    end
    d = m_mem[c][r]; v = m_rdy[c][r];
    req = !v ? "R6" : (m_rem[c][r] ? "R5" : "R3");
    for (int p = 0; p < NP; p++)
      if (p / NA != c && p_en[p] && int'(p_tag[p]) == r) begin
        d = p_dat[p]; v = 1'b1; req = "R4"; nh++;
      end
    for (int p = 0; p < NP; p++)
      if (p / NA == c && b_en[p] && int'(b_tag[p]) == r) begin
        d = b_dat[p]; v = 1'b1; req = "R2"; nh++;
      end
    if (nh > 1) req = "R7";
    if (sweep_r1) req = "R1";
  endtask

  task automatic step();
    logic [DW-1:0] d;
    logic v;
    string req;
    logic [2*NREG-1:0] exp_rdy;
    #2;
    for (int i = 0; i < NRD; i++) begin
      predict(int'(b_clu[i]), int'(b_rt[i]), d, v, req);
      chk(req, rd_vld[i], rd_data[i*DW +: DW], v, d);
    end
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < NREG; r++) begin
        predict(c, r, d, v, req);
        exp_rdy[c*NREG + r] = v;
      end
    n_chk++;
    if (ready !== exp_rdy) begin
      n_bad++;
      $display("FAIL %s: ready got %h expected %h", sweep_r1 ? "R1" : "R9", ready, exp_rdy);
    end
    @(posedge clk);
    if (inv_en && int'(inv_tag) < NREG) begin
      m_rdy[0][inv_tag] = 1'b0; m_rdy[1][inv_tag] = 1'b0;
    end
    for (int p = 0; p < NP; p++)
      if (p_en[p] && int'(p_tag[p]) < NREG) begin
        m_mem[1 - p/NA][p_tag[p]] = p_dat[p];
        m_rdy[1 - p/NA][p_tag[p]] = 1'b1;
        m_rem[1 - p/NA][p_tag[p]] = 1'b1;
      end
    for (int p = 0; p < NP; p++)
      if (b_en[p] && int'(b_tag[p]) < NREG) begin
        m_mem[p/NA][b_tag[p]] = b_dat[p];
        m_rdy[p/NA][b_tag[p]] = 1'b1;
        m_rem[p/NA][b_tag[p]] = 1'b0;
      end
    for (int p = 0; p < NP; p++) begin
      p_en[p] = b_en[p]; p_tag[p] = b_tag[p]; p_dat[p] = b_dat[p];
    end
    @(negedge clk);
  endtask

  task automatic idle();
    for (int p = 0; p < NP; p++) begin
      b_en[p] = 1'b0; b_tag[p] = '0; b_dat[p] = '0;
    end
    inv_en = 1'b0; inv_tag = '0;
  endtask

  task automatic wr(int p, int t, logic [DW-1:0] d);
    b_en[p] = 1'b1; b_tag[p] = TW'(t); b_dat[p] = d;
  endtask

  task automatic rd4(int t);
    b_clu[0] = 1'b0; b_rt[0] = TW'(t);
    b_clu[1] = 1'b1; b_rt[1] = TW'(t);
    b_clu[2] = 1'b0; b_rt[2] = TW'(t + 1);
    b_clu[3] = 1'b1; b_rt[3] = TW'(t + 1);
  endtask

  task automatic rnd(int span);
    for (int p = 0; p < NP; p++) begin
      b_en[p] = 1'($urandom % 2);
      b_tag[p] = TW'($urandom % span);
      b_dat[p] = {$urandom, $urandom};
    end
    inv_en = ($urandom % 6) == 0;
    inv_tag = TW'($urandom % span);
    for (int i = 0; i < NRD; i++) begin
      b_clu[i] = 1'($urandom % 2);
      b_rt[i] = TW'($urandom % span);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got no end of run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    for (int i = 0; i < NRD; i++) begin b_clu[i] = 1'b0; b_rt[i] = '0; end
    for (int p = 0; p < NP; p++) begin p_en[p] = 1'b0; p_tag[p] = '0; p_dat[p] = '0; end
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < NREG; r++) begin
        m_mem[c][r] = '0; m_rdy[c][r] = 1'b1; m_rem[c][r] = 1'b0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: full sweep of both copies after reset
    sweep_r1 = 1'b1;
    for (int t = 0; t < NREG; t += 2) begin rd4(t); step(); end
    sweep_r1 = 1'b0;

    // R2/R4/R3/R5: one result from cluster 0, observed over four cycles
    rd4(5); wr(1, 5, 64'hA5A5_0000_1111_2222); step();
    idle(); step(); step(); step();
    // same from cluster 1 toward cluster 0
    wr(2, 6, 64'h0123_4567_89AB_CDEF); rd4(5); step();
    idle(); step(); step();

    // R7: two ports of one cluster on one tag, then local versus arriving remote
    rd4(9); wr(0, 9, 64'h1); wr(1, 9, 64'h2); step();
    idle(); wr(3, 10, 64'h3); rd4(9); step();
    idle(); wr(0, 10, 64'h4); wr(2, 9, 64'h5); step();
    idle(); wr(1, 10, 64'h6); rd4(9); step();
    idle(); rd4(9); step(); step();

    // R6: invalidate, hold pending, then refill from the other cluster
    idle(); inv_en = 1'b1; inv_tag = 7'd5; rd4(5); step();
    idle(); step(); step();
    wr(3, 5, 64'hFEED); step();
    idle(); step(); step();
    inv_en = 1'b1; inv_tag = 7'd6; wr(0, 6, 64'hBEEF); rd4(5); step();
    idle(); step();

    // R8: out-of-range writes and reads
    wr(0, 80, 64'hDEAD); wr(3, 83, 64'hDEAD); rd4(79); step();
    idle(); rd4(80); step(); rd4(82); step();

    for (int n = 0; n < 3000; n++) begin rnd(8); step(); end
    for (int n = 0; n < 3000; n++) begin rnd(84); step(); end
    idle(); step(); step();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule